// File: doc/BRIEF.md
# Region-Decoded Bus Read Unit

This unit answers processor data reads on a 32-bit address space. The top eight address bits pick a region, and the offset is masked to that region's window, so a small memory repeats across the whole window. Each region store is modelled as pattern-backed content: its bytes are a fixed function of region number and masked offset, so every mirror and alignment effect shows up at the data port. Word reads at an unaligned address come back rotated. Halfword reads at an odd address also come back rotated. A signed halfword mode sign-extends the loaded value.

Some reads have no backing store: a hole in the map, an I/O register that cannot be read, or a boot ROM that is locked while code runs outside it. For these reads the unit returns open-bus data taken from the instruction stream at the current program counter. While code runs outside the boot ROM, low boot ROM addresses return a latched copy of the last word fetched there while the boot ROM was open. Two save-memory regions hand their reads to external responder ports, but only while those ports are enabled.

A read is a single-cycle request. The response data and a valid strobe are registered and appear one cycle later.

Top module: `bus_read_unit`

## Requirements
- R1: Region is addr[31:23+1]. Masked offsets are: region 0 &0x3FFF; region 2 &0x3FFFF; region 3 &0x7FFF; regions 4, 5, 7 &0x3FF; region 6 &0x1FFFF; regions 8–12 &0x1FFFFFF. Regions 2, 3, 5, 6, 7 and 8–12 (and region 0 while pc[31:24]==0) return fill bytes. The fill byte at masked offset o of region r is (r·SEED mod 256) ^ o[7:0] ^ (3·o[15:8] mod 256) ^ (5·o[24:16] mod 256). Multi-byte values are little-endian, starting at the aligned offset (o&~3 for a word, o&~1 for a halfword). Address bits outside the mask have no effect.
- R2: A region-0 read with pc[31:24]==0 latches the aligned word it reads. When pc[31:24]!=0, region-0 addresses below 0x4000 return that latched word (the halfword at addr bit 1, or the byte at addr[1:0]). Region-0 addresses at or above 0x4000 are then unmapped. Reset clears the latch to 0.
- R3: An I/O (region 4) read is legal only if addr < 0x04000400 and the halfword index is readable. The index is o[9:1] for byte and halfword reads and {o[9:2],0} for word reads. A halfword index h is readable when h mod IO_GAP != IO_GAP−1. A word read whose upper halfword index is not readable returns the lower halfword zero-extended. Any other I/O read is unmapped.
- R4: A word read returns its 32-bit value rotated right by 8·addr[1:0].
- R5: Let v be a 16-bit value. An unsigned halfword read returns v zero-extended at an even address and (v>>8)|(v<<24) at an odd address. A signed halfword read (sgn=1) returns v sign-extended from bit 15 at an even address and v[15:8] sign-extended at an odd address.
- R6: Byte reads (size 0) return the byte zero-extended, whatever sgn is. Size encodings are 0 byte, 1 halfword, 2 word.
- R7: An unmapped read uses q = pc[31:24] and its mask m (0 for regions outside R1). With wide_state=1, a word read takes the word at pc&m aligned, a halfword read takes the halfword at (pc+(addr&2))&m, and a byte read takes the byte at (pc+addr[1:0])&m. With wide_state=0, word and halfword reads take the halfword at pc&m (duplicated into both halves for a word), and a byte read takes the byte at (pc+addr[0])&m. R4 and R5 then apply.
- R8: Region 13 with ee_en asserts ee_sel and returns ee_rdata. Region 14 with save_en asserts save_sel and returns save_rdata. Both are returned without rotation or extension, except that byte reads keep bits [7:0] only. With its enable low, either region is unmapped.
- R9: rsp_valid is high exactly in the cycle after a cycle with req high, and rdata holds that read's result.
- R10: After reset, rsp_valid and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Read request this cycle |
| addr | input | 32 | Byte address |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| sgn | input | 1 | Signed halfword load |
| pc | input | 32 | Current program-counter fetch address |
| wide_state | input | 1 | 1 = 32-bit instruction state, 0 = 16-bit |
| ee_en | input | 1 | Serial save memory present |
| save_en | input | 1 | Parallel/flash save memory present |
| ee_sel | output | 1 | Read routed to the serial save port |
| save_sel | output | 1 | Read routed to the parallel save port |
| ee_rdata | input | 32 | Serial save port response data |
| save_rdata | input | 32 | Parallel save port response data |
| rsp_valid | output | 1 | Response strobe |
| rdata | output | 32 | Response data |

## Verification
The bench builds the unit with IO_GAP=16 and SEED=0x1D. With IO_GAP=16, the first 64 bytes of I/O space already contain a readable halfword, an unreadable halfword, and a word whose upper half is unreadable, so a plain byte-by-byte sweep reaches every I/O legality case. With a nonzero seed, each region's fill pattern differs. The sweep also reads each region at the base address and at base plus mask+1, which exposes any wrong mask, any wrong region choice, and every rotation and extension case.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  typedef enum logic [2:0] {
    SRC_FILL, SRC_PROT, SRC_IO, SRC_EE, SRC_SAVE, SRC_OPEN
  } src_e;

  // Window mask of each region; zero for regions with no store.
  function automatic logic [24:0] region_mask(input logic [7:0] r);
    case (r)
      8'd0:                             return 25'h0003FFF;
      8'd2:                             return 25'h003FFFF;
      8'd3:                             return 25'h0007FFF;
      8'd4, 8'd5, 8'd7:                 return 25'h00003FF;
      8'd6:                             return 25'h001FFFF;
      8'd8, 8'd9, 8'd10, 8'd11, 8'd12:  return 25'h1FFFFFF;
      default:                          return 25'h0000000;
    endcase
  endfunction

  // Pattern content of a region store at masked offset o.
  function automatic logic [7:0] fill_byte(input logic [7:0] r, input logic [24:0] o,
                                           input logic [7:0] seed);
    logic [7:0] a, b;
    logic [8:0] c;
    a = r * seed;
    b = o[15:8] * 8'd3;
    c = o[24:16] * 9'd5;
    return a ^ o[7:0] ^ b ^ c[7:0];
  endfunction

  function automatic logic [15:0] fill_half(input logic [7:0] r, input logic [24:0] o,
                                            input logic [7:0] seed);
    return {fill_byte(r, o + 25'd1, seed), fill_byte(r, o, seed)};
  endfunction

  function automatic logic [31:0] fill_word(input logic [7:0] r, input logic [24:0] o,
                                            input logic [7:0] seed);
    return {fill_half(r, o + 25'd2, seed), fill_half(r, o, seed)};
  endfunction

  function automatic logic [31:0] rotr_bytes(input logic [31:0] v, input logic [1:0] n);
    case (n)
      2'd0:    return v;
      2'd1:    return {v[7:0], v[31:8]};
      2'd2:    return {v[15:0], v[31:16]};
      default: return {v[23:0], v[31:24]};
    endcase
  endfunction

  function automatic logic io_readable(input logic [8:0] h, input int gap);
    return (int'(h) % gap) != (gap - 1);
  endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int IO_GAP = 16
) (
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic [7:0]  pc_top,
  input  logic        ee_en,
  input  logic        save_en,
  output src_e        src,
  output logic [7:0]  region,
  output logic [24:0] offset,
  output logic        io_hi_ok
);
  logic       locked;
  logic [8:0] h_lo;
  logic [8:0] h_hi;

  always_comb begin
    region   = addr[31:24];
    offset   = addr[24:0] & region_mask(addr[31:24]);
    locked   = pc_top != 8'd0;
    h_lo     = (size == SZ_WORD) ? {offset[9:2], 1'b0} : offset[9:1];
    h_hi     = {offset[9:2], 1'b1};
    io_hi_ok = io_readable(h_hi, IO_GAP);
    case (region)
      8'd0:   src = !locked ? SRC_FILL : (addr[23:14] == 10'd0 ? SRC_PROT : SRC_OPEN);
      8'd2, 8'd3, 8'd5, 8'd6, 8'd7,
      8'd8, 8'd9, 8'd10, 8'd11, 8'd12:
              src = SRC_FILL;
      8'd4:   src = (addr[23:10] == 14'd0 && io_readable(h_lo, IO_GAP)) ? SRC_IO : SRC_OPEN;
      8'd13:  src = ee_en ? SRC_EE : SRC_OPEN;
      8'd14:  src = save_en ? SRC_SAVE : SRC_OPEN;
      default: src = SRC_OPEN;
    endcase
  end
endmodule

// File: rtl/bru_align.sv
module bru_align
  import bru_pkg::*;
(
  input  logic [31:0] raw,
  input  logic [1:0]  size,
  input  logic        sgn,
  input  logic [1:0]  lsb,
  input  logic        pass,
  output logic [31:0] data
);
  logic [15:0] v;

  always_comb begin
    v = raw[15:0];
    if (size == SZ_BYTE)
      data = {24'd0, raw[7:0]};
    else if (pass)
      data = raw;
    else if (size == SZ_WORD)
      data = rotr_bytes(raw, lsb);
    else if (sgn)
      data = lsb[0] ? {{24{v[15]}}, v[15:8]} : {{16{v[15]}}, v};
    else
      data = lsb[0] ? {v[7:0], 16'd0, v[15:8]} : {16'd0, v};
  end
endmodule

// File: rtl/bus_read_unit.sv
module bus_read_unit
  import bru_pkg::*;
#(
  parameter int         IO_GAP = 16,
  parameter logic [7:0] SEED   = 8'h1D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic        sgn,
  input  logic [31:0] pc,
  input  logic        wide_state,
  input  logic        ee_en,
  input  logic        save_en,
  output logic        ee_sel,
  output logic        save_sel,
  input  logic [31:0] ee_rdata,
  input  logic [31:0] save_rdata,
  output logic        rsp_valid,
  output logic [31:0] rdata
);
  src_e        src;
  logic [7:0]  region;
  logic [24:0] offset;
  logic        io_hi_ok;
  logic [31:0] prot_q;
  logic        boot_fetch;
  logic [7:0]  q_reg;
  logic [24:0] q_mask;
  logic [24:0] q_off;
  logic [24:0] q_hoff;
  logic [24:0] q_boff;
  logic [31:0] open_val;
  logic [31:0] raw;
  logic [31:0] aligned;
  logic        pass;

  bru_decode #(.IO_GAP(IO_GAP)) u_dec (
    .addr(addr), .size(size), .pc_top(pc[31:24]), .ee_en(ee_en), .save_en(save_en),
    .src(src), .region(region), .offset(offset), .io_hi_ok(io_hi_ok)
  );

  // Open-bus value from the instruction stream.
  always_comb begin
    q_reg  = pc[31:24];
    q_mask = region_mask(q_reg);
    q_off  = pc[24:0] & q_mask;
    q_hoff = (pc[24:0] + {22'd0, wide_state & addr[1], 2'b00} / 25'd2) & q_mask;
    q_boff = (pc[24:0] + {23'd0, wide_state ? addr[1:0] : {1'b0, addr[0]}}) & q_mask;
    case (size)
      SZ_WORD: open_val = wide_state ? fill_word(q_reg, {q_off[24:2], 2'b00}, SEED)
                                     : {2{fill_half(q_reg, {q_off[24:1], 1'b0}, SEED)}};
      SZ_HALF: open_val = {16'd0, fill_half(q_reg, {q_hoff[24:1], 1'b0}, SEED)};
      default: open_val = {24'd0, fill_byte(q_reg, q_boff, SEED)};
    endcase
  end

  always_comb begin
    pass = 1'b0;
    case (src)
      SRC_FILL, SRC_IO: begin
        if (size == SZ_WORD)
          raw = (src == SRC_IO && !io_hi_ok)
              ? {16'd0, fill_half(region, {offset[24:2], 2'b00}, SEED)}
              : fill_word(region, {offset[24:2], 2'b00}, SEED);
        else if (size == SZ_HALF)
          raw = {16'd0, fill_half(region, {offset[24:1], 1'b0}, SEED)};
        else
          raw = {24'd0, fill_byte(region, offset, SEED)};
      end
      SRC_PROT: begin
        if (size == SZ_WORD)      raw = prot_q;
        else if (size == SZ_HALF) raw = {16'd0, addr[1] ? prot_q[31:16] : prot_q[15:0]};
        else                      raw = {24'd0, prot_q[8*addr[1:0] +: 8]};
      end
      SRC_EE:   begin raw = ee_rdata;   pass = 1'b1; end
      SRC_SAVE: begin raw = save_rdata; pass = 1'b1; end
      default:  raw = open_val;
    endcase
  end

  bru_align u_align (
    .raw(raw), .size(size), .sgn(sgn), .lsb(addr[1:0]), .pass(pass), .data(aligned)
  );

  assign ee_sel     = req && (src == SRC_EE);
  assign save_sel   = req && (src == SRC_SAVE);
  assign boot_fetch = req && (region == 8'd0) && (pc[31:24] == 8'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rdata     <= 32'd0;
      prot_q    <= 32'd0;
    end else begin
      rsp_valid <= req;
      if (req) rdata <= aligned;
      if (boot_fetch) prot_q <= fill_word(8'd0, {offset[24:2], 2'b00}, SEED);
    end
  end

  assert_valid_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);
  assert_byte_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == SZ_BYTE) |=> rdata[31:8] == 24'd0);
  assert_signed_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == SZ_HALF && sgn && addr[0] && !pass) |=> rdata[31:8] == {24{rdata[7]}});
  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_sel && save_sel) && (!ee_sel || ee_en) && (!save_sel || save_en));
  assert_prot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_fetch |=> $stable(prot_q));
endmodule

// File: tb/bus_read_unit_test.sv
module bus_read_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = '0;
  logic        sgn = 1'b0;
  logic [31:0] pc = '0;
  logic        wide_state = 1'b1;
  logic        ee_en = 1'b0;
  logic        save_en = 1'b0;
  logic        ee_sel, save_sel;
  logic [31:0] ee_rdata = 32'hA1B2C3D4;
  logic [31:0] save_rdata = 32'h5E6F7081;
  logic        rsp_valid;
  logic [31:0] rdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [31:0] prot_m = 32'd0;

  always #5 clk = ~clk;

  bus_read_unit uut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .size(size), .sgn(sgn),
    .pc(pc), .wide_state(wide_state), .ee_en(ee_en), .save_en(save_en),
    .ee_sel(ee_sel), .save_sel(save_sel), .ee_rdata(ee_rdata), .save_rdata(save_rdata),
    .rsp_valid(rsp_valid), .rdata(rdata)
  );

  function automatic logic [31:0] bmask(input logic [7:0] r);
    if (r == 0) return 32'h3FFF;
    if (r == 2) return 32'h3FFFF;
    if (r == 3) return 32'h7FFF;
    if (r == 4 || r == 5 || r == 7) return 32'h3FF;
    if (r == 6) return 32'h1FFFF;
    if (r >= 8 && r <= 12) return 32'h1FFFFFF;
    return 32'h0;
  endfunction

  function automatic logic [7:0] bb(input logic [7:0] r, input logic [31:0] o);
    int t;
    t = (int'(r) * 29) ^ int'(o & 255) ^ (int'((o >> 8) & 255) * 3) ^ (int'((o >> 16) & 511) * 5);
    return 8'(t & 255);
  endfunction

  function automatic logic [31:0] bh(input logic [7:0] r, input logic [31:0] o);
    return {16'd0, bb(r, o + 1), bb(r, o)};
  endfunction

  function automatic logic [31:0] bw(input logic [7:0] r, input logic [31:0] o);
    return (bh(r, o + 2) << 16) | bh(r, o);
  endfunction

  function automatic bit ioflag(input logic [31:0] h);
    return (h % 16) != 15;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [1:0] sz, input logic sg);
    logic [7:0] r, q;
    logic [31:0] m, o, qm, raw;
    int kind;
    int s;
    r = a[31:24]; m = bmask(r); o = a & m;
    kind = 5;
    if (r == 0) kind = (pc[31:24] == 0) ? 0 : ((a < 32'h4000) ? 1 : 5);
    else if (r == 2 || r == 3 || r == 5 || r == 6 || r == 7 || (r >= 8 && r <= 12)) kind = 0;
    else if (r == 4) begin
      if (a < 32'h04000400 && ioflag(sz == 2 ? ((o >> 1) & ~32'd1) : (o >> 1))) kind = 2;
    end
    else if (r == 13 && ee_en) kind = 3;
    else if (r == 14 && save_en) kind = 4;
    if (kind == 3 || kind == 4) begin
      raw = (kind == 3) ? ee_rdata : save_rdata;
      return (sz == 0) ? (raw & 32'hFF) : raw;
    end
    q = pc[31:24]; qm = bmask(q);
    if (sz == 0) begin
      if (kind == 0 || kind == 2) return bb(r, o);
      if (kind == 1) return (prot_m >> (8 * a[1:0])) & 32'hFF;
      return bb(q, (pc + (wide_state ? (a & 3) : (a & 1))) & qm);
    end
    if (sz == 1) begin
      if (kind == 0 || kind == 2) raw = bh(r, o & ~32'd1);
      else if (kind == 1) raw = (prot_m >> (a[1] ? 16 : 0)) & 32'hFFFF;
      else if (wide_state) raw = bh(q, ((pc + (a & 2)) & qm) & ~32'd1);
      else raw = bh(q, (pc & qm) & ~32'd1);
      if (a[0]) raw = (raw >> 8) | (raw << 24);
      if (sg) begin
        if (a[0]) raw = {{24{raw[7]}}, raw[7:0]};
        else raw = {{16{raw[15]}}, raw[15:0]};
      end
      return raw;
    end
    if (kind == 0) raw = bw(r, o & ~32'd3);
    else if (kind == 2) raw = ioflag(((o >> 1) & ~32'd1) + 1) ? bw(4, o & ~32'd3) : bh(4, o & ~32'd3);
    else if (kind == 1) raw = prot_m;
    else if (wide_state) raw = bw(q, (pc & qm) & ~32'd3);
    else raw = bh(q, (pc & qm) & ~32'd1) * 32'h00010001;
    s = 8 * int'(a[1:0]);
    return (raw >> s) | (raw << (32 - s));
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic sg);
    logic [31:0] exp;
    exp = model(a, sz, sg);
    @(negedge clk);
    addr = a; size = sz; sgn = sg; req = 1'b1;
    #1;
    if (a[31:24] == 13 || a[31:24] == 14) begin
      check("R8 ee_sel", {31'd0, ee_sel}, {31'd0, a[31:24] == 13 && ee_en});
      check("R8 save_sel", {31'd0, save_sel}, {31'd0, a[31:24] == 14 && save_en});
    end
    if (a[31:24] == 0 && pc[31:24] == 0) prot_m = bw(0, (a & 32'h3FFF) & ~32'd3);
    @(negedge clk);
    req = 1'b0;
    check({tag, " valid R9"}, {31'd0, rsp_valid}, 32'd1);
    check(tag, rdata, exp);
  endtask

  task automatic sweep_addr(input string tag, input logic [31:0] a);
    for (int sz = 0; sz < 3; sz++)
      for (int sg = 0; sg < 2; sg++)
        rd(tag, a, 2'(sz), 1'(sg));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [8];
    bases = '{32'h00000000, 32'h02000000, 32'h03000000, 32'h05000000,
              32'h06000000, 32'h07000000, 32'h08000000, 32'h0C000000};
    repeat (3) @(negedge clk);
    check("R10 reset valid", {31'd0, rsp_valid}, 32'd0);
    check("R10 reset data", rdata, 32'd0);
    rst_n = 1'b1;

    // R1 R4 R5 R6: every mapped region, low offsets and a mirror copy.
    pc = 32'h00000200;
    foreach (bases[i]) begin
      logic [31:0] mk;
      mk = bmask(bases[i][31:24]);
      for (int k = 0; k < 4; k++) begin
        sweep_addr("R1/R4/R5/R6 base", bases[i] + 32'h134 + 32'(k));
        sweep_addr("R1 mirror", bases[i] + mk + 1 + 32'h134 + 32'(k));
      end
    end

    // R3: I/O sweep across readable, hole and upper-hole words.
    pc = 32'h08000100;
    for (int k = 0; k < 64; k++) sweep_addr("R3 io", 32'h04000000 + 32'(k));
    sweep_addr("R3 io beyond", 32'h04000400);
    sweep_addr("R3 io mirror", 32'h04FFF81C);

    // R2: latch then protected reads.
    pc = 32'h00000100;
    rd("R2 open fetch", 32'h00000124, 2'd2, 1'b0);
    pc = 32'h08000100;
    for (int k = 0; k < 4; k++) sweep_addr("R2 protected", 32'h00000010 + 32'(k));
    sweep_addr("R2 above window", 32'h00004000);
    check("R2 latch value", prot_m, bw(0, 32'h124));

    // R7: holes under both instruction states and two pc regions.
    for (int w = 0; w < 2; w++) begin
      wide_state = 1'(w);
      pc = 32'h08000100;
      for (int k = 0; k < 4; k++) begin
        sweep_addr("R7 hole1", 32'h01000000 + 32'(k));
        sweep_addr("R7 hole15", 32'hF0000000 + 32'(k));
      end
      pc = 32'h02001236;
      for (int k = 0; k < 4; k++) sweep_addr("R7 wram pc", 32'h0F000000 + 32'(k));
    end
    wide_state = 1'b1;

    // R8: save ports on and off.
    for (int e = 0; e < 4; e++) begin
      ee_en = e[0]; save_en = e[1];
      for (int k = 0; k < 2; k++) begin
        sweep_addr("R8 ee", 32'h0D000000 + 32'(k));
        sweep_addr("R8 save", 32'h0E000001 + 32'(k));
      end
    end

    // R9: idle cycle leaves no strobe.
    @(negedge clk);
    check("R9 idle", {31'd0, rsp_valid}, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule